// File: doc/BRIEF.md
# Video Level Calibration Loop

This block closes, in logic, the calibration loop that holds the offset and reference of an external video ADC so that the digitised input lands on fixed code values. It watches the 8-bit samples of the colour channel that carries composite sync. It also follows a pixel position that it counts itself, starting from a line-start strobe that the recovered pixel-clock timing provides. Once per line it takes one sample from the middle of the sync pulse and one sample from the middle of the back porch.

Each of these two samples is compared with a half-code target: 74.5 for the sync tip and 123.5 for the blank level. Each comparison gives a single-cycle "raise" or "lower" pulse to an external analog actuator. The sync-tip decision drives the input offset. The blank-level decision drives the ADC reference. When both levels are held on target, full white falls near code 246. A lock input, driven by the clock-recovery loop, gates the whole block. While lock is low the block emits nothing and freezes its position.

The block finds its windows only from the pixel count and never decodes the video. The line is 1344 pixels long. Position 0 is the first pixel of sync, so sync occupies positions 0..127 and the back porch 128..255. Active video and then the front porch fill the rest of the line.

Top module: `vid_level_cal`

## Requirements
- R1: After reset all four adjust outputs are low. No pulse is produced until a locked cycle has seen `line_start_i` high.
- R2: A locked cycle with `line_start_i` high carries position 0. Every later locked cycle carries the previous locked position plus one, and the position wraps from 1343 to 0 when no new line start arrives.
- R3: A locked sample at position 64 with a value of 74 or less produces `ofs_up_o` high for exactly the next cycle.
- R4: A locked sample at position 64 with a value of 75 or more produces `ofs_dn_o` high for exactly the next cycle.
- R5: A locked sample at position 192 produces either `ref_up_o` (value of 123 or less, blank code must rise) or `ref_dn_o` (value of 124 or more) high for exactly the next cycle.
- R6: Samples at any other position produce no pulse, so each output pair pulses at most once per line.
- R7: While `lock_i` is low, no pulse is emitted, `line_start_i` is ignored and the position is held. Counting resumes from the held position on the next locked cycle.
- R8: The up and down outputs of a pair are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Clock recovery locked; enables the loop |
| line_start_i | input | 1 | High on the first sync pixel of a line |
| sample_i | input | 8 | ADC code of the sync-carrying channel |
| ofs_up_o | output | 1 | Pulse: raise the input offset (sync code too low) |
| ofs_dn_o | output | 1 | Pulse: lower the input offset |
| ref_up_o | output | 1 | Pulse: adjust the reference so blank code rises |
| ref_dn_o | output | 1 | Pulse: adjust the reference so blank code falls |

## Verification
Each adjust pulse is due exactly one clock after the cycle in which the tap sample is presented, because the decision register is the only stage between input and output. The driver keeps its own model of the pixel position, built from the line-start, wrap and lock rules. When it presents a sample at position 64 or 192, it queues the expected pulse pattern stamped with the following cycle number. The monitor compares the outputs against that stamp after every falling edge. It flags any pulse with no queued entry and any entry whose cycle has passed.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  // one actuator command: raise or lower, never both
  typedef struct packed {
    logic up;
    logic dn;
  } nudge_t;
endpackage

// File: rtl/vlc_line_pos.sv
module vlc_line_pos #(
  parameter int unsigned LINE_LEN = 1344,
  parameter int unsigned POS_W    = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_i,
  input  logic             line_start_i,
  output logic [POS_W-1:0] pos_o,
  output logic             pos_ok_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(LINE_LEN - 1);

  logic [POS_W-1:0] pos_q;   // position of the last locked sample
  logic             ok_q;    // a line start has been seen

  // position of the sample presented this cycle
  always_comb begin
    if (line_start_i)      pos_o = '0;
    else if (pos_q == LAST) pos_o = '0;
    else                   pos_o = pos_q + POS_W'(1);
    pos_ok_o = line_start_i | ok_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= LAST;
      ok_q  <= 1'b0;
    end else if (lock_i) begin
      pos_q <= pos_o;
      if (line_start_i) ok_q <= 1'b1;
    end
  end

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST);
  assert_start_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (lock_i && line_start_i) |=> (pos_q == '0));
  assert_hold_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
    !lock_i |=> $stable(pos_q) && $stable(ok_q));
endmodule

// File: rtl/vlc_level_judge.sv
module vlc_level_judge
  import vlc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned POS_W    = 11,
  parameter int unsigned TAP_POS  = 64,
  parameter int unsigned LOW_MAX  = 74
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lock_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                pos_ok_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output nudge_t              nudge_o
);
  logic strobe;
  logic below;
  nudge_t nudge_q;

  assign strobe = lock_i & pos_ok_i & (pos_i == POS_W'(TAP_POS));
  assign below  = (sample_i <= SAMPLE_W'(LOW_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      nudge_q <= '0;
    end else begin
      nudge_q.up <= strobe & below;
      nudge_q.dn <= strobe & ~below;
    end
  end

  assign nudge_o = nudge_q;

  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(nudge_q.up && nudge_q.dn));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (nudge_q.up || nudge_q.dn) |=> !(nudge_q.up || nudge_q.dn));
endmodule

// File: rtl/vid_level_cal.sv
module vid_level_cal
  import vlc_pkg::*;
#(
  parameter int unsigned SAMPLE_W      = 8,
  parameter int unsigned LINE_LEN      = 1344,
  parameter int unsigned SYNC_LEN      = 128,
  parameter int unsigned BACK_LEN      = 128,
  parameter int unsigned SYNC_LOW_MAX  = 74,
  parameter int unsigned BLANK_LOW_MAX = 123
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lock_i,
  input  logic                line_start_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                ofs_up_o,
  output logic                ofs_dn_o,
  output logic                ref_up_o,
  output logic                ref_dn_o
);
  localparam int unsigned POS_W     = $clog2(LINE_LEN);
  localparam int unsigned N_LOOPS   = 2;
  localparam int unsigned SYNC_TAP  = SYNC_LEN / 2;
  localparam int unsigned BLANK_TAP = SYNC_LEN + BACK_LEN / 2;
  localparam int unsigned TAP_AT [N_LOOPS] = '{SYNC_TAP, BLANK_TAP};
  localparam int unsigned LOW_AT [N_LOOPS] = '{SYNC_LOW_MAX, BLANK_LOW_MAX};

  logic [POS_W-1:0] pos;
  logic             pos_ok;
  nudge_t           nudge [N_LOOPS];

  vlc_line_pos #(.LINE_LEN(LINE_LEN), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .lock_i(lock_i), .line_start_i(line_start_i),
    .pos_o(pos), .pos_ok_o(pos_ok)
  );

  // loop 0: sync tip -> offset, loop 1: blank -> reference
  for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
    vlc_level_judge #(
      .SAMPLE_W(SAMPLE_W), .POS_W(POS_W),
      .TAP_POS(TAP_AT[g]), .LOW_MAX(LOW_AT[g])
    ) u_judge (
      .clk(clk), .rst(rst), .lock_i(lock_i), .pos_i(pos), .pos_ok_i(pos_ok),
      .sample_i(sample_i), .nudge_o(nudge[g])
    );
  end

  assign ofs_up_o = nudge[0].up;
  assign ofs_dn_o = nudge[0].dn;
  assign ref_up_o = nudge[1].up;
  assign ref_dn_o = nudge[1].dn;

  assert_quiet_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
    !lock_i |=> !(ofs_up_o || ofs_dn_o || ref_up_o || ref_dn_o));
  assert_sync_window_R3: assert property (@(posedge clk) disable iff (rst)
    (ofs_up_o || ofs_dn_o) |-> $past(pos == POS_W'(SYNC_TAP)));
  assert_blank_window_R5: assert property (@(posedge clk) disable iff (rst)
    (ref_up_o || ref_dn_o) |-> $past(pos == POS_W'(BLANK_TAP)));
  assert_needs_start_R1: assert property (@(posedge clk) disable iff (rst)
    (ofs_up_o || ofs_dn_o || ref_up_o || ref_dn_o) |-> $past(pos_ok));
endmodule

// File: tb/tb_vid_level_cal.sv
`timescale 1ns/1ps
module tb_vid_level_cal;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock = 1'b0;
  logic ls = 1'b0;
  logic [7:0] smp = 8'd0;
  logic ou, od, ru, rd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int         stamp;
    logic [3:0] pat;   // {ofs_up, ofs_dn, ref_up, ref_dn}
    string      req;
  } exp_t;
  exp_t q[$];

  int mpos = 1343;
  bit mok = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vid_level_cal dut (
    .clk(clk), .rst(rst), .lock_i(lock), .line_start_i(ls), .sample_i(smp),
    .ofs_up_o(ou), .ofs_dn_o(od), .ref_up_o(ru), .ref_dn_o(rd)
  );

  // driver: one cycle of stimulus, with expectation from the position model
  task automatic step(input bit l, input bit k, input logic [7:0] sv,
                      input logic [7:0] bv, input logic [7:0] other,
                      input string req);
    int p;
    bit ok;
    p = -1;
    ok = 1'b0;
    @(negedge clk);
    ls = l;
    lock = k;
    if (k) begin
      p = l ? 0 : ((mpos == 1343) ? 0 : mpos + 1);
      ok = l | mok;
      mpos = p;
      if (l) mok = 1'b1;
    end
    if (k && p == 64)       smp = sv;
    else if (k && p == 192) smp = bv;
    else                    smp = other;
    if (k && ok && p == 64)
      q.push_back('{cyc + 1, {sv <= 8'd74, sv > 8'd74, 2'b00}, req});
    if (k && ok && p == 192)
      q.push_back('{cyc + 1, {2'b00, bv <= 8'd123, bv > 8'd123}, req});
  endtask

  task automatic run_line(input bit first_ls, input bit k, input logic [7:0] sv,
                          input logic [7:0] bv, input logic [7:0] other,
                          input string req);
    for (int i = 0; i < 1344; i++)
      step(first_ls && i == 0, k, sv, bv, other, req);
  endtask

  // monitor: compare outputs one cycle after the tap sample
  always @(negedge clk) begin
    logic [3:0] obs;
    if (!rst) begin
      obs = {ou, od, ru, rd};
      if (q.size() > 0 && q[0].stamp < cyc) begin
        checks++; errors++;
        $display("FAIL %s: missed pulse due at cycle %0d, actual %b expected %b",
                 q[0].req, q[0].stamp, obs, q[0].pat);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].stamp == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (obs !== e.pat) begin
          errors++;
          $display("FAIL %s: cycle %0d actual %b expected %b", e.req, cyc, obs, e.pat);
        end
      end else if (obs !== 4'b0000) begin
        checks++; errors++;
        $display("FAIL R6: unexpected pulse at cycle %0d actual %b expected 0000", cyc, obs);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;   // R1 reset state
    if ({ou, od, ru, rd} !== 4'b0000) begin
      errors++;
      $display("FAIL R1: outputs in reset actual %b expected 0000", {ou, od, ru, rd});
    end
    rst = 1'b0;
    // R1: locked samples but no line start yet -> nothing
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 8'd10, 8'd10, 8'd10, "R1");
    mpos = 1343;  // position before first start is undefined; restart model
    // R3, R5: just below both targets
    run_line(1'b1, 1'b1, 8'd74, 8'd123, 8'd200, "R3/R5 low edge");
    // R4, R5: just above both targets
    run_line(1'b1, 1'b1, 8'd75, 8'd124, 8'd0, "R4/R5 high edge");
    // extremes, distractors of opposite sense elsewhere (R6)
    run_line(1'b1, 1'b1, 8'd0, 8'd255, 8'd128, "R6 extremes");
    run_line(1'b1, 1'b1, 8'd255, 8'd0, 8'd50, "R6 extremes");
    // R2: no new line start, position wraps and decisions repeat
    run_line(1'b0, 1'b1, 8'd80, 8'd100, 8'd74, "R2 wrap");
    // R7: lock drops mid-line, line start ignored while unlocked
    step(1'b1, 1'b1, 8'd60, 8'd130, 8'd0, "R7");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1, 8'd60, 8'd130, 8'd0, "R7");
    for (int i = 0; i < 150; i++)
      step(i == 40, 1'b0, 8'd60, 8'd130, 8'd70, "R7");
    run_line(1'b0, 1'b1, 8'd60, 8'd130, 8'd0, "R7 resume");
    // R7: whole unlocked line with sync-like data -> quiet
    run_line(1'b1, 1'b0, 8'd20, 8'd20, 8'd20, "R7");
    // R2: early line start after sync tap; sync decision repeats in new line
    run_line(1'b1, 1'b1, 8'd90, 8'd110, 8'd0, "R2 early start");
    run_line(1'b1, 1'b1, 8'd70, 8'd125, 8'd0, "R2 R8");
    repeat (4) step(1'b0, 1'b1, 8'd0, 8'd0, 8'd0, "R6");
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6: pending expectations actual %0d expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule